// File: doc/BRIEF.md
# Status Register Write-Protection Controller

This block keeps the configuration and latch bits of a serial memory's 8-bit status byte. It also decides, one command at a time, whether a status write or a data-array write may go ahead. Decoded command strobes come in from the serial front end: write-enable, write-disable, status write with its data byte, and data write with its target address. The block also takes the level of the active-low write-protect pin and the busy, under-voltage and increment flags that other logic drives. It returns the status byte for reads, the current protection mode, and a grant or reject pulse for each status or data write.

Protection has two layers. The first is the software layer: two block-protect bits select a top portion of a 1024-byte array that can never be written. The second is the hardware layer: once the persistent disable bit is set and the pin is low, the status register is frozen. This also freezes the block-protect field, so the protected region becomes read-only until the pin goes high again. The grant and reject pulses are combinational and appear in the same cycle as the strobe. The register updates land on the next rising edge.

Top module: `swp_ctrl`

## Requirements
- R1: After reset the status byte reads {disable=0, UV, 0, INC, protect=00, enable-latch=0, WIP}. Bit 7 is the disable bit, bit 6 mirrors `uv_in`, bit 5 is always 0, bit 4 mirrors `inc_in`, bits 3:2 are the protect field, bit 1 is the enable latch and bit 0 mirrors `wip_in`.
- R2: A write-enable strobe sets the enable latch (bit 1). A write-disable strobe clears it.
- R3: When the disable bit is 0 and the latch is 1, a status write is granted whatever the pin level. It loads bit 7 and bits 3:2 from `wrsr_data[7]` and `wrsr_data[3:2]`; all other data bits are ignored.
- R4: When the disable bit is 1 and the pin is high, a status write is granted only if the latch is 1. Otherwise it is rejected and the status byte is left unchanged.
- R5: `hw_protect` is 1 exactly when the disable bit is 1 and the pin is low. In that mode every status write is rejected, even with the latch set, and bits 7 and 3:2 keep their values.
- R6: Hardware-protected mode is entered in either order: by setting the disable bit while the pin is low, or by lowering the pin after the bit is set. It is left only by driving the pin high, and the disable bit can only clear through a write granted outside that mode.
- R7: A data write is rejected when its address lies in the protected region. The protect field encodes the region as 00 = none, 01 = addresses 768..1023, 10 = addresses 512..1023, 11 = all addresses. This holds in both modes.
- R8: A data write outside the protected region is granted only if the latch is 1.
- R9: Every status write or data write clears the enable latch on the next edge, whether it was granted or rejected.
- R10: While `wip_in` is 1, write-enable and write-disable have no effect, and every status or data write is rejected. A rejected write still clears the latch and changes no other bit.
- R11: An undriven (high-impedance or unknown) pin level is taken as low.
- R12: When several strobes arrive in one cycle, only one acts, in the priority order status write, data write, write-enable, write-disable. `wr_grant` and `wr_reject` pulse only for status or data writes, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_data | input | 8 | Data byte carried by the status write |
| cmd_write | input | 1 | Data-array write strobe |
| write_addr | input | ADDR_W | Target address of the data write |
| wp_n | input | 1 | Write-protect pin level, active low |
| wip_in | input | 1 | Write-in-progress (busy) flag |
| uv_in | input | 1 | Under-voltage flag, shown in bit 6 |
| inc_in | input | 1 | Increment flag, shown in bit 4 |
| status_out | output | 8 | Status byte for reads |
| hw_protect | output | 1 | 1 = hardware-protected mode, 0 = software-protected |
| wr_grant | output | 1 | Current status or data write is accepted |
| wr_reject | output | 1 | Current status or data write is refused |

## Verification
The bench works through both routes into hardware-protected mode and the single route out. A design that latched the mode, or that tied it only to the bit-write order, would keep rejecting status writes after the pin rises, or would miss the pin-falls-later route. It sweeps every protect-field value against addresses on each side of the quarter and half boundaries, where an off-by-one decode grants a write into the protected top of the array. It checks that a busy flag blocks enable-latch changes while a rejected write still clears the latch. A design that skipped that clear would leave the latch armed for a later write. A randomized phase with colliding strobes and a floating pin catches wrong strobe priority and a floating level read as high.

// File: rtl/swp_pkg.sv
package swp_pkg;

  localparam int STAT_W     = 8;
  localparam int BIT_DIS    = 7;
  localparam int BIT_UV     = 6;
  localparam int BIT_INC    = 4;
  localparam int BIT_PROT_H = 3;
  localparam int BIT_PROT_L = 2;
  localparam int BIT_LATCH  = 1;
  localparam int BIT_BUSY   = 0;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_STATUS_WR,
    OP_DATA_WR,
    OP_LATCH_SET,
    OP_LATCH_CLR
  } op_e;

  typedef enum logic {
    MODE_SOFT = 1'b0,
    MODE_HARD = 1'b1
  } prot_mode_e;

endpackage

// File: rtl/swp_rst_sync.sv
module swp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/swp_op_pick.sv
module swp_op_pick
  import swp_pkg::*;
(
  input  logic cmd_wren,
  input  logic cmd_wrdi,
  input  logic cmd_wrsr,
  input  logic cmd_write,
  output op_e  op
);

  // Fixed priority: status write, data write, latch set, latch clear.
  always_comb begin
    if (cmd_wrsr)       op = OP_STATUS_WR;
    else if (cmd_write) op = OP_DATA_WR;
    else if (cmd_wren)  op = OP_LATCH_SET;
    else if (cmd_wrdi)  op = OP_LATCH_CLR;
    else                op = OP_NONE;
  end

endmodule

// File: rtl/swp_region.sv
module swp_region #(
  parameter int ADDR_W = 10
) (
  input  logic [1:0]        prot_field,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_region
);

  localparam int TOP = ADDR_W - 1;

  logic top_quarter;
  logic top_half;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top_quarter = addr[TOP] & addr[TOP-1];
      assign top_half    = addr[TOP];
    end else begin : g_narrow
      assign top_quarter = addr[TOP];
      assign top_half    = addr[TOP];
    end
  endgenerate

  always_comb begin
    unique case (prot_field)
      2'b00:   in_region = 1'b0;
      2'b01:   in_region = top_quarter;
      2'b10:   in_region = top_half;
      default: in_region = 1'b1;
    endcase
  end

endmodule

// File: rtl/swp_gate.sv
module swp_gate
  import swp_pkg::*;
(
  input  op_e  op,
  input  logic busy,
  input  logic latch,
  input  logic hard_mode,
  input  logic in_region,
  output logic grant,
  output logic reject,
  output logic load_cfg,
  output logic latch_set,
  output logic latch_clr
);

  logic ok;

  always_comb begin
    ok        = 1'b0;
    grant     = 1'b0;
    reject    = 1'b0;
    load_cfg  = 1'b0;
    latch_set = 1'b0;
    latch_clr = 1'b0;
    unique case (op)
      OP_STATUS_WR: begin
        ok        = !busy && latch && !hard_mode;
        grant     = ok;
        reject    = !ok;
        load_cfg  = ok;
        latch_clr = 1'b1;
      end
      OP_DATA_WR: begin
        ok        = !busy && latch && !in_region;
        grant     = ok;
        reject    = !ok;
        latch_clr = 1'b1;
      end
      OP_LATCH_SET: latch_set = !busy;
      OP_LATCH_CLR: latch_clr = !busy;
      default: ;
    endcase
  end

endmodule

// File: rtl/swp_ctrl.sv
module swp_ctrl
  import swp_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] write_addr,
  input  logic              wp_n,
  input  logic              wip_in,
  input  logic              uv_in,
  input  logic              inc_in,
  output logic [7:0]        status_out,
  output logic              hw_protect,
  output logic              wr_grant,
  output logic              wr_reject
);

  logic       rst_sync_n;
  logic       pin_high;
  prot_mode_e mode;
  op_e        op;
  logic       in_region;
  logic       load_cfg, latch_set, latch_clr;

  logic       dis_q, dis_d;
  logic [1:0] prot_q, prot_d;
  logic       latch_q, latch_d;
  logic       cfg_en, latch_en;
  logic       unused_data;

  swp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // Only a definite 1 counts as high; an X or Z level falls to the else branch.
  always_comb begin
    if (wp_n) pin_high = 1'b1;
    else      pin_high = 1'b0;
  end

  assign mode = (dis_q && !pin_high) ? MODE_HARD : MODE_SOFT;

  swp_op_pick u_pick (
    .cmd_wren (cmd_wren),
    .cmd_wrdi (cmd_wrdi),
    .cmd_wrsr (cmd_wrsr),
    .cmd_write(cmd_write),
    .op       (op)
  );

  swp_region #(.ADDR_W(ADDR_W)) u_region (
    .prot_field(prot_q),
    .addr      (write_addr),
    .in_region (in_region)
  );

  swp_gate u_gate (
    .op       (op),
    .busy     (wip_in),
    .latch    (latch_q),
    .hard_mode(mode == MODE_HARD),
    .in_region(in_region),
    .grant    (wr_grant),
    .reject   (wr_reject),
    .load_cfg (load_cfg),
    .latch_set(latch_set),
    .latch_clr(latch_clr)
  );

  assign unused_data = ^{wrsr_data[6:4], wrsr_data[1:0]};

  // Next state
  always_comb begin
    cfg_en   = load_cfg;
    dis_d    = wrsr_data[BIT_DIS];
    prot_d   = wrsr_data[BIT_PROT_H:BIT_PROT_L];
    latch_en = latch_set | latch_clr;
    latch_d  = latch_set & ~latch_clr;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dis_q  <= 1'b0;
      prot_q <= 2'b00;
    end else if (cfg_en) begin
      dis_q  <= dis_d;
      prot_q <= prot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   latch_q <= 1'b0;
    else if (latch_en) latch_q <= latch_d;
  end

  always_comb begin
    status_out             = '0;
    status_out[BIT_DIS]    = dis_q;
    status_out[BIT_UV]     = uv_in;
    status_out[BIT_INC]    = inc_in;
    status_out[BIT_PROT_H] = prot_q[1];
    status_out[BIT_PROT_L] = prot_q[0];
    status_out[BIT_LATCH]  = latch_q;
    status_out[BIT_BUSY]   = wip_in;
  end

  assign hw_protect = (mode == MODE_HARD);

endmodule

// File: rtl/swp_ctrl_chk.sv
module swp_ctrl_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       cmd_wren,
  input logic       cmd_wrsr,
  input logic       cmd_write,
  input logic       wip_in,
  input logic [7:0] status_out,
  input logic       hw_protect,
  input logic       wr_grant,
  input logic       wr_reject
);

  AST_GRANT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_ok)
    !(wr_grant && wr_reject)); // R12

  AST_LATCH_SETS: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_wren && !cmd_wrsr && !cmd_write && !wip_in) |=> status_out[1]); // R2

  AST_LATCH_CLEARS_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_wrsr || cmd_write) |=> !status_out[1]); // R9

  AST_HARD_MODE_FREEZES: assert property (@(posedge clk) disable iff (!rst_ok)
    (hw_protect && cmd_wrsr) |=> ($stable(status_out[7]) && $stable(status_out[3:2]))); // R5

  AST_DISABLE_FALLS_OUTSIDE_HARD: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(status_out[7]) |-> !$past(hw_protect)); // R6

  AST_BUSY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_ok)
    wip_in |-> !wr_grant); // R10

  AST_FULL_REGION_BLOCKS: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_write && !cmd_wrsr && status_out[3:2] == 2'b11) |-> !wr_grant); // R7

endmodule

bind swp_ctrl swp_ctrl_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .cmd_wren  (cmd_wren),
  .cmd_wrsr  (cmd_wrsr),
  .cmd_write (cmd_write),
  .wip_in    (wip_in),
  .status_out(status_out),
  .hw_protect(hw_protect),
  .wr_grant  (wr_grant),
  .wr_reject (wr_reject)
);

// File: tb/swp_ctrl_test.sv
module swp_ctrl_test;

  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          t_wren, t_wrdi, t_wrsr, t_write;
  logic [7:0]    t_data;
  logic [AW-1:0] t_addr;
  logic          t_pin, t_wip, t_uv, t_inc;
  logic [7:0]    status_out;
  logic          hw_protect, wr_grant, wr_reject;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference state
  bit       m_dis;
  bit [1:0] m_prot;
  bit       m_latch;

  always #4 clk = ~clk;

  swp_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_wren(t_wren), .cmd_wrdi(t_wrdi), .cmd_wrsr(t_wrsr),
    .wrsr_data(t_data), .cmd_write(t_write), .write_addr(t_addr),
    .wp_n(t_pin), .wip_in(t_wip), .uv_in(t_uv), .inc_in(t_inc),
    .status_out(status_out), .hw_protect(hw_protect),
    .wr_grant(wr_grant), .wr_reject(wr_reject)
  );

  function automatic bit pin_is_high();
    return (t_pin === 1'b1);
  endfunction

  function automatic bit addr_locked(input bit [1:0] p, input int a);
    case (p)
      2'd0: return 1'b0;
      2'd1: return a >= 768;
      2'd2: return a >= 512;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit write_ok();
    if (t_wrsr)  return !t_wip && m_latch && !(m_dis && !pin_is_high());
    if (t_write) return !t_wip && m_latch && !addr_locked(m_prot, int'(t_addr));
    return 1'b0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    bit       is_wr;
    bit       ok;
    bit [7:0] exp_stat;
    is_wr    = t_wrsr || t_write;
    ok       = write_ok();
    exp_stat = {m_dis, t_uv, 1'b0, t_inc, m_prot, m_latch, t_wip};
    check(tag, "status", int'(status_out), int'(exp_stat));
    check(tag, "hw_protect", int'(hw_protect), int'(m_dis && !pin_is_high()));
    check(tag, "grant", int'(wr_grant), int'(is_wr && ok));
    check(tag, "reject", int'(wr_reject), int'(is_wr && !ok));
  endtask

  task automatic model_update();
    bit ok;
    ok = write_ok();
    if (!rst_n) begin
      m_dis = 0; m_prot = 0; m_latch = 0;
    end else if (t_wrsr) begin
      if (ok) begin m_dis = t_data[7]; m_prot = t_data[3:2]; end
      m_latch = 0;
    end else if (t_write) begin
      m_latch = 0;
    end else if (t_wren) begin
      if (!t_wip) m_latch = 1;
    end else if (t_wrdi) begin
      if (!t_wip) m_latch = 0;
    end
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    compare(tag);
    @(posedge clk);
    model_update();
    #1;
  endtask

  task automatic clear_cmds();
    t_wren = 0; t_wrdi = 0; t_wrsr = 0; t_write = 0;
  endtask

  task automatic do_wren(input string tag);  t_wren = 1; step(tag); clear_cmds(); endtask
  task automatic do_wrdi(input string tag);  t_wrdi = 1; step(tag); clear_cmds(); endtask
  task automatic do_idle(input string tag);  step(tag); endtask
  task automatic do_wrsr(input string tag, input bit [7:0] d);
    t_wrsr = 1; t_data = d; step(tag); clear_cmds();
  endtask
  task automatic do_write(input string tag, input int a);
    t_write = 1; t_addr = AW'(a); step(tag); clear_cmds();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int addrs[6] = '{0, 511, 512, 767, 768, 1023};
    clear_cmds();
    t_data = 0; t_addr = 0; t_pin = 1; t_wip = 0; t_uv = 0; t_inc = 0;
    m_dis = 0; m_prot = 0; m_latch = 0;
    rst_n = 0;
    #1;
    repeat (3) do_idle("R1");
    rst_n = 1;
    repeat (4) do_idle("R1");
    @(negedge clk);
    check("R1", "reset status byte", int'(status_out), 8'h00);
    @(posedge clk); #1;
    t_uv = 1; t_inc = 1; do_idle("R1"); t_uv = 0; t_inc = 0;

    // R2 latch set and clear
    do_wren("R2"); do_idle("R2"); do_wrdi("R2"); do_idle("R2");

    // R3 write with pin low while disable bit 0, extra bits ignored; R6 entry by setting bit
    t_pin = 0;
    do_wren("R3"); do_wrsr("R3", 8'hFF); do_idle("R6");
    // R5 write in hard mode rejected, latch set first
    do_wren("R5"); do_wrsr("R5", 8'h00); do_idle("R5");
    // R6 leave by pin high; R4 write needs latch
    t_pin = 1; do_idle("R6");
    do_wrsr("R4", 8'h00); do_idle("R4");
    do_wren("R4"); do_wrsr("R4", 8'h00); do_idle("R4");
    // R6 other order: set bit with pin high, then pin low
    do_wren("R6"); do_wrsr("R6", 8'h80); do_idle("R6");
    t_pin = 0; do_idle("R6");
    do_wren("R8"); do_write("R8", 1023); do_idle("R8");
    do_write("R8", 5);
    // R11 floating pin behaves as low
    t_pin = 1'bz; do_idle("R11");
    do_wren("R11"); do_wrsr("R11", 8'h00); do_idle("R11");
    t_pin = 1; do_wren("R6"); do_wrsr("R6", 8'h00); do_idle("R6");

    // R7 region sweep
    for (int p = 0; p < 4; p++) begin
      do_wren("R7"); do_wrsr("R7", 8'(p << 2));
      foreach (addrs[i]) begin
        do_wren("R7"); do_write("R7", addrs[i]);
        do_write("R9", addrs[i]);
      end
    end
    do_wren("R3"); do_wrsr("R3", 8'h00);

    // R10 busy
    do_wren("R10"); t_wip = 1;
    do_wrdi("R10"); do_idle("R10");
    do_wrsr("R10", 8'h8C); do_idle("R10");
    do_wren("R10"); do_idle("R10");
    t_wip = 0; do_wren("R10"); t_wip = 1; do_write("R10", 0); t_wip = 0; do_idle("R10");

    // R12 random mix of colliding strobes, pin levels and flags
    for (int n = 0; n < 2000; n++) begin
      int r;
      r = $urandom_range(0, 7);
      t_pin   = (r == 0) ? 1'bz : ((r < 4) ? 1'b0 : 1'b1);
      t_wren  = ($urandom_range(0, 2) == 0);
      t_wrdi  = ($urandom_range(0, 4) == 0);
      t_wrsr  = ($urandom_range(0, 4) == 0);
      t_write = ($urandom_range(0, 3) == 0);
      t_data  = 8'($urandom);
      t_addr  = AW'($urandom);
      t_wip   = ($urandom_range(0, 9) == 0);
      t_uv    = 1'($urandom);
      t_inc   = 1'($urandom);
      step("R12");
    end
    clear_cmds(); t_wip = 0; t_pin = 1;
    do_idle("R12");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule